// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt lines into a single request for a processor. Each line latches into a status bit. A per-line build-time mask picks the sensing style: a rising edge sets the bit for an edge line, and a high level sets it for a level line. Software sees the block through a simple word-addressed register port. It masks lines individually. It clears latched bits by writing ones. It reads a vector word that names the lowest-numbered line that is both latched and unmasked.

The processor request is asserted only when two control bits are both on and at least one unmasked line is latched. Reads come back one cycle after the address is presented. Writes take effect at the clock edge where the write strobe is high.

Top module: `irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status, enable and control words clear to zero. `irq_o` is low after that edge.
- R2: Writing word 4 ORs the written mask into the enable word. Writing word 2 loads the enable word directly. Reading word 2 returns the enable word.
- R3: Writing word 5 clears the enable bits set in the written mask and leaves every other enable bit as it was.
- R4: Writing word 3 clears the status bits set in the written mask. An all-ones write clears every status bit at once. An edge line held high is not latched again by an acknowledge.
- R5: An edge line (EDGE_MASK bit = 1) sets its status bit on a low-to-high transition. The bit stays set after the line falls, until it is acknowledged.
- R6: A level line (EDGE_MASK bit = 0) sets its status bit in every cycle the line is high. An acknowledge issued while the line is still high leaves the bit set. Reading word 0 returns the status word.
- R7: Reading word 1 returns status AND enable.
- R8: Reading word 6 returns the index of the lowest-numbered bit of status AND enable, or 0xFFFFFFFF when that word is zero.
- R9: `irq_o` is high in the cycle after one where control bit 0 and control bit 1 (word 7) are both set and status AND enable is nonzero. Otherwise `irq_o` is low.
- R10: Writes to words 0, 1 and 6 change nothing. Words 3, 4 and 5 read as zero. Every read returns its data on `rdata_o` one clock edge after `addr_i` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt lines, synchronous to clk |
| addr_i | input | 3 | Word address of the register port |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the previous address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume that the interrupt lines are already synchronous to `clk`. They also assume that at most one register write happens per cycle, because the port carries a single address. The properties that compare against earlier cycles are gated by a count of edges since reset. This lets them ignore any line activity during reset. The stimulus changes lines and bus signals only on the falling edge. It keeps the lines low while reset is high. It pulses edge lines for exactly one cycle or holds them for several cycles, so that both the capture-once and the held-high cases occur.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT   = 3'd0,
    REG_PEND   = 3'd1,
    REG_EN     = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VEC    = 3'd6,
    REG_CTRL   = 3'd7
  } irqc_reg_e;

  localparam int CTRL_ON_BIT = 0;
  localparam int CTRL_HW_BIT = 1;
  localparam int CTRL_W      = 2;
endpackage

// File: rtl/irqc_sense.sv
`timescale 1ns/1ps
module irqc_sense #(
  parameter int          N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] capture_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src_i[g];
      end
      assign capture_o[g] = src_i[g] & ~prev_q;
    end else begin : g_level
      assign capture_o[g] = src_i[g];
    end
  end
endmodule

// File: rtl/irqc_lowest.sv
`timescale 1ns/1ps
module irqc_lowest #(
  parameter int N     = 32,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      capture_i,
  input  logic [N-1:0]      ack_mask_i,
  input  logic              en_load_i,
  input  logic [N-1:0]      en_data_i,
  input  logic [N-1:0]      set_mask_i,
  input  logic [N-1:0]      clr_mask_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  output logic [N-1:0]      status_o,
  output logic [N-1:0]      enable_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [N-1:0] enable_d;

  always_comb begin
    if (en_load_i) enable_d = en_data_i;
    else           enable_d = (enable_o | set_mask_i) & ~clr_mask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
      ctrl_o   <= '0;
    end else begin
      status_o <= (status_o & ~ack_mask_i) | capture_i;
      enable_o <= enable_d;
      if (ctrl_we_i) ctrl_o <= ctrl_data_i;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] capture;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [CTRL_W-1:0]  master_q;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] ack_mask, set_mask, clr_mask;
  logic               en_load, ctrl_we;
  logic               vec_found;
  logic [IDX_W-1:0]   vec_idx;
  logic [DATA_W-1:0]  vec_word;
  logic [DATA_W-1:0]  rd_next;

  assign wmask    = wdata_i[NUM_SRC-1:0];
  assign ack_mask = (wr_en_i && addr_i == REG_ACK)   ? wmask : '0;
  assign set_mask = (wr_en_i && addr_i == REG_SETEN) ? wmask : '0;
  assign clr_mask = (wr_en_i && addr_i == REG_CLREN) ? wmask : '0;
  assign en_load  = wr_en_i && addr_i == REG_EN;
  assign ctrl_we  = wr_en_i && addr_i == REG_CTRL;

  irqc_sense #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_sense (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .capture_o (capture)
  );

  irqc_regs #(.N(NUM_SRC)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .capture_i   (capture),
    .ack_mask_i  (ack_mask),
    .en_load_i   (en_load),
    .en_data_i   (wmask),
    .set_mask_i  (set_mask),
    .clr_mask_i  (clr_mask),
    .ctrl_we_i   (ctrl_we),
    .ctrl_data_i (wdata_i[CTRL_W-1:0]),
    .status_o    (status_q),
    .enable_o    (enable_q),
    .ctrl_o      (master_q)
  );

  assign pending = status_q & enable_q;

  irqc_lowest #(.N(NUM_SRC), .IDX_W(IDX_W)) u_lowest (
    .req_i   (pending),
    .found_o (vec_found),
    .idx_o   (vec_idx)
  );

  assign vec_word = vec_found ? DATA_W'(vec_idx) : '1;

  always_comb begin
    unique case (addr_i)
      REG_STAT: rd_next = DATA_W'(status_q);
      REG_PEND: rd_next = DATA_W'(pending);
      REG_EN:   rd_next = DATA_W'(enable_q);
      REG_VEC:  rd_next = vec_word;
      REG_CTRL: rd_next = DATA_W'(master_q);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      rdata_o <= rd_next;
      irq_o   <= master_q[CTRL_ON_BIT] & master_q[CTRL_HW_BIT] & (|pending);
    end
  end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int          N         = 32,
  parameter logic [31:0] EDGE_MASK = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      src_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [N-1:0]      status,
  input logic [N-1:0]      enable,
  input logic [CTRL_W-1:0] master
);
  localparam logic [N-1:0] EDGE_N = EDGE_MASK[N-1:0];

  logic [1:0]   live_cnt;
  logic [N-1:0] ackm;

  always_ff @(posedge clk) begin
    if (rst)                 live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  assign ackm = (wr_en_i && addr_i == REG_ACK) ? wdata_i[N-1:0] : '0;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (irq_o == 1'b0 && status == '0 && enable == '0 && master == '0));

  p_set_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1 && $past(wr_en_i && addr_i == REG_SETEN))
      |-> ((enable & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

  p_clear_enable_r3: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1 && $past(wr_en_i && addr_i == REG_CLREN))
      |-> ((enable & $past(wdata_i[N-1:0])) == '0));

  p_ack_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd2)
      |-> ((status & $past(ackm) & EDGE_N & ~($past(src_i) & ~$past(src_i, 2))) == '0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1) |-> ((($past(status) & ~$past(ackm)) & ~status) == '0));

  p_level_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1) |-> (($past(src_i) & ~EDGE_N & ~status) == '0));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1 && irq_o)
      |-> ($past(master) == 2'b11 && $past(|(status & enable))));

  p_irq_raised_r9: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1 && $past(master == 2'b11 && (|(status & enable)))) |-> irq_o);
endmodule

bind irq_ctrl irqc_checker #(.N(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .src_i   (src_i),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .status  (status_q),
  .enable  (enable_q),
  .master  (master_q)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  localparam int          N    = 32;
  localparam logic [31:0] EDGE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src;
  logic [2:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  irq_ctrl #(.NUM_SRC(N), .EDGE_MASK(EDGE)) u_dut (
    .clk(clk), .rst(rst), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";
  logic [31:0] src_hold = '0;

  // behavioural reference state
  logic [31:0] m_stat, m_en, m_prev, m_rd;
  logic [1:0]  m_ctl;
  logic        m_irq;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic step(input logic r, input logic [2:0] a, input logic we,
                      input logic [31:0] wd, input logic [31:0] s);
    logic [31:0] n_stat, n_en, n_rd, ackv;
    logic [1:0]  n_ctl;
    logic        n_irq;
    rst = r; addr = a; wr_en = we; wdata = wd; src = s;
    if (r) begin
      n_stat = 0; n_en = 0; n_ctl = 0; n_rd = 0; n_irq = 0;
    end else begin
      ackv   = (we && a == 3'd3) ? wd : 32'h0;
      n_stat = (m_stat & ~ackv) | (s & ~EDGE) | (s & ~m_prev & EDGE);
      n_en   = m_en;
      if (we && a == 3'd2) n_en = wd;
      if (we && a == 3'd4) n_en = m_en | wd;
      if (we && a == 3'd5) n_en = m_en & ~wd;
      n_ctl  = (we && a == 3'd7) ? wd[1:0] : m_ctl;
      case (a)
        3'd0: n_rd = m_stat;
        3'd1: n_rd = m_stat & m_en;
        3'd2: n_rd = m_en;
        3'd6: n_rd = lowest(m_stat & m_en);
        3'd7: n_rd = {30'h0, m_ctl};
        default: n_rd = 0;
      endcase
      n_irq = (m_ctl == 2'b11) && ((m_stat & m_en) != 0);
    end
    @(posedge clk);
    m_stat = n_stat; m_en = n_en; m_ctl = n_ctl; m_rd = n_rd; m_irq = n_irq;
    m_prev = r ? 32'h0 : s;
    @(negedge clk);
    check(rdata, m_rd, cur_req);
    check({31'h0, irq}, {31'h0, m_irq}, cur_req);
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 1'b0, 32'h0, src_hold);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(1'b0, a, 1'b1, d, src_hold);
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] exp, input string req);
    step(1'b0, a, 1'b0, 32'h0, src_hold);
    check(rdata, exp, req);
  endtask

  initial begin
    #(5.0 * 150000);
    $display("FAIL watchdog expired actual=running expected=done");
    n_err++;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; addr = 0; wr_en = 0; wdata = 0; src = 0;
    m_stat = 0; m_en = 0; m_prev = 0; m_rd = 0; m_ctl = 0; m_irq = 0;
    @(negedge clk);
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, 3'd0, 1'b0, 32'h0, 32'h0);
    check({31'h0, irq}, 32'h0, "R1");
    rd_expect(3'd0, 32'h0, "R1");
    rd_expect(3'd2, 32'h0, "R1");
    rd_expect(3'd7, 32'h0, "R1");

    cur_req = "R2";
    wr(3'd4, 32'h0000_00F1);
    wr(3'd4, 32'h8000_0100);
    rd_expect(3'd2, 32'h8000_01F1, "R2");
    wr(3'd2, 32'h0000_000F);
    rd_expect(3'd2, 32'h0000_000F, "R2");

    cur_req = "R3";
    wr(3'd5, 32'h0000_0006);
    rd_expect(3'd2, 32'h0000_0009, "R3");
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd4, 32'h8012_0001);
    rd_expect(3'd2, 32'h8012_0001, "R3");

    wr(3'd7, 32'h0000_0003);
    rd_expect(3'd7, 32'h0000_0003, "R9");

    cur_req = "R6";
    src_hold = 32'h0000_0001;
    idle(); idle();
    rd_expect(3'd0, 32'h0000_0001, "R6");
    check({31'h0, irq}, 32'h1, "R9");
    rd_expect(3'd6, 32'h0, "R8");
    wr(3'd3, 32'h0000_0001);
    rd_expect(3'd0, 32'h0000_0001, "R6");
    src_hold = 32'h0;
    idle();
    rd_expect(3'd0, 32'h0000_0001, "R6");
    cur_req = "R4";
    wr(3'd3, 32'h0000_0001);
    rd_expect(3'd0, 32'h0, "R4");
    rd_expect(3'd6, 32'hFFFF_FFFF, "R8");
    check({31'h0, irq}, 32'h0, "R9");

    cur_req = "R5";
    src_hold = 32'h8000_0000; idle();
    src_hold = 32'h0; idle();
    rd_expect(3'd0, 32'h8000_0000, "R5");
    idle(); idle(); idle();
    rd_expect(3'd0, 32'h8000_0000, "R5");

    cur_req = "R4";
    src_hold = 32'h0002_0000; idle(); idle();
    rd_expect(3'd0, 32'h8002_0000, "R5");
    wr(3'd3, 32'h0002_0000);
    rd_expect(3'd0, 32'h8000_0000, "R4");
    src_hold = 32'h0; idle();

    cur_req = "R8";
    rd_expect(3'd6, 32'd31, "R8");
    src_hold = 32'h0012_0000; idle();
    src_hold = 32'h0; idle();
    rd_expect(3'd6, 32'd17, "R8");
    wr(3'd3, 32'h0002_0000);
    rd_expect(3'd6, 32'd20, "R8");

    cur_req = "R7";
    src_hold = 32'h0200_0000; idle();
    src_hold = 32'h0; idle();
    rd_expect(3'd0, 32'h8210_0000, "R7");
    rd_expect(3'd1, 32'h8010_0000, "R7");

    cur_req = "R9";
    wr(3'd7, 32'h1); idle();
    check({31'h0, irq}, 32'h0, "R9");
    wr(3'd7, 32'h2); idle();
    check({31'h0, irq}, 32'h0, "R9");
    wr(3'd7, 32'h3); idle();
    check({31'h0, irq}, 32'h1, "R9");

    cur_req = "R10";
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);
    wr(3'd6, 32'h0);
    rd_expect(3'd0, 32'h8210_0000, "R10");
    rd_expect(3'd4, 32'h0, "R10");
    rd_expect(3'd3, 32'h0, "R10");

    cur_req = "R4";
    wr(3'd3, 32'hFFFF_FFFF);
    rd_expect(3'd0, 32'h0, "R4");
    rd_expect(3'd6, 32'hFFFF_FFFF, "R8");
    idle();
    check({31'h0, irq}, 32'h0, "R9");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule